// File: doc/BRIEF.md
# Exception trace packet sequencer

This block sits between a processor's retirement and exception signals and a trace packet output. It decides which abstract trace records to produce, and in what order, when retirements, taken branches and exception entries arrive. A small accumulator collects one atom for each retired waypoint instruction. The block also tracks the last retired instruction and whether anything has retired since the last exception entry. From that state it chooses among three outcomes: promote the last instruction to a waypoint, skip the promotion when exceptions arrive back-to-back, or replace it with a synchronisation record when tracing was switched on between two back-to-back exceptions.

Each accepted input cycle produces up to three records. They are staged internally and handed out one per cycle on a valid/ready stream. While records are still staged, `in_ready_o` is low, and the event source must hold its inputs until it is high again. Byte-level compression and encoding of the records are left to a later stage.

Top module: `exc_trace_seq`

## Requirements
- R1: After reset, `pkt_valid_o` is low, `in_ready_o` is high and the atom accumulator is empty.
- R2: Each accepted retire with `retire_wpt_i` high appends one atom (1 = E from `retire_taken_i`, 0 = N) at the next free bit of `pkt_atoms_o` (bit 0 = oldest). Reaching 5 atoms emits an atom record (kind 0) with `pkt_cnt_o` = 5 at once.
- R3: An exception whose last retired instruction was not a waypoint emits, in order: pending atoms (kind 0), a waypoint update (kind 1) carrying that instruction's address, and an exception branch (kind 2).
- R4: An exception whose last retired instruction was a waypoint emits only pending atoms and the exception branch.
- R5: An exception with no retire since the previous exception emits no waypoint update, so two exception branch records follow each other.
- R6: An exception branch carries the vector as its address and the type in `pkt_exc_o` (0 = IRQ with vector 0x18, 1 = FIQ with vector 0x1C).
- R7: A taken-branch event, including an exception return, emits a normal branch record (kind 3) with the destination, preceded by any pending atoms.
- R8: If trace was low at any time after the previous exception and no instruction has retired since it, the next exception emits a sync record (kind 4) carrying the previous vector, then the exception branch, and no waypoint update.
- R9: While `trace_en_i` is low, no record is presented, the accumulator is emptied and staged records are dropped. Retire and exception state still follows execution.
- R10: While any record is staged, `in_ready_o` is low. A presented record that is not taken keeps its fields stable.
- R11: A retire and an exception accepted in the same cycle are handled as the retire followed by the exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_en_i | input | 1 | Trace enable |
| in_ready_o | output | 1 | Input events accepted this cycle |
| retire_valid_i | input | 1 | An instruction retires |
| retire_addr_i | input | AW | Retired instruction address |
| retire_wpt_i | input | 1 | Retired instruction is a waypoint |
| retire_taken_i | input | 1 | Waypoint outcome, 1 = E, 0 = N |
| branch_valid_i | input | 1 | Taken branch or exception return |
| branch_dest_i | input | AW | Branch destination |
| exc_valid_i | input | 1 | Exception entry |
| exc_type_i | input | 1 | 0 = IRQ, 1 = FIQ |
| pkt_valid_o | output | 1 | Record presented |
| pkt_ready_i | input | 1 | Record taken |
| pkt_kind_o | output | 3 | 0 atoms, 1 waypoint update, 2 exception branch, 3 branch, 4 sync |
| pkt_addr_o | output | AW | Address field |
| pkt_exc_o | output | 1 | Exception type of an exception branch |
| pkt_atoms_o | output | AMAX | Atom bits, bit 0 oldest |
| pkt_cnt_o | output | CW | Number of atoms in an atom record |

## Verification
Two functions can fall in the same cycle. A retire and an exception can land together, and the atom that fills the accumulator can arrive with an address-carrying event. Both are provoked by asserting `retire_valid_i` with `exc_valid_i` or `branch_valid_i` in one cycle, both on purpose and at random. They are judged against a queue-based model that applies the retire first. The model expects one atom record holding every pending atom, then the waypoint update or sync, then the branch record.

// File: rtl/exc_trace_pkg.sv
package exc_trace_pkg;
  typedef enum logic [2:0] {
    PK_ATOM  = 3'd0,
    PK_WPT   = 3'd1,
    PK_EXC   = 3'd2,
    PK_BR    = 3'd3,
    PK_ISYNC = 3'd4
  } pkt_kind_e;
endpackage

// File: rtl/trace_exec_track.sv
module trace_exec_track #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trace_en_i,
  input  logic          ret_i,
  input  logic [AW-1:0] ret_addr_i,
  input  logic          ret_wpt_i,
  input  logic          exc_i,
  input  logic [AW-1:0] exc_vec_i,
  input  logic          any_ev_i,
  output logic [AW-1:0] last_addr_o,
  output logic          last_wpt_o,
  output logic          ret_since_o,
  output logic [AW-1:0] last_vec_o,
  output logic          vec_valid_o,
  output logic          sync_pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_addr_o <= '0;
      last_wpt_o  <= 1'b0;
      ret_since_o <= 1'b0;
      last_vec_o  <= '0;
      vec_valid_o <= 1'b0;
      sync_pend_o <= 1'b0;
    end else begin
      if (ret_i) begin
        last_addr_o <= ret_addr_i;
        last_wpt_o  <= ret_wpt_i;
      end
      // exception clears the flag even if a retire lands in the same cycle
      if (exc_i) begin
        ret_since_o <= 1'b0;
        last_vec_o  <= exc_vec_i;
        vec_valid_o <= 1'b1;
      end else if (ret_i) begin
        ret_since_o <= 1'b1;
      end
      if (!trace_en_i)    sync_pend_o <= 1'b1;
      else if (any_ev_i)  sync_pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/trace_atom_acc.sv
module trace_atom_acc #(
  parameter int AMAX = 5,
  parameter int CW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            push_i,
  input  logic            bit_i,
  input  logic            flush_i,
  output logic [CW-1:0]   nxt_cnt_o,
  output logic [AMAX-1:0] nxt_bits_o
);
  logic [CW-1:0]   cnt_q;
  logic [AMAX-1:0] bits_q;

  always_comb begin
    nxt_bits_o = bits_q;
    for (int i = 0; i < AMAX; i++) begin
      if (push_i && cnt_q == CW'(i)) nxt_bits_o[i] = bit_i;
    end
    nxt_cnt_o = cnt_q + CW'(push_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bits_q <= '0;
    end else if (clr_i || flush_i) begin
      cnt_q  <= '0;
      bits_q <= '0;
    end else begin
      cnt_q  <= nxt_cnt_o;
      bits_q <= nxt_bits_o;
    end
  end
endmodule

// File: rtl/trace_pkt_slots.sv
module trace_pkt_slots #(
  parameter int NS = 3,
  parameter int W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 load_i,
  input  logic [NS-1:0]        load_vld_i,
  input  logic [NS-1:0][W-1:0] load_rec_i,
  input  logic                 pop_i,
  output logic                 busy_o,
  output logic                 head_vld_o,
  output logic [W-1:0]         head_rec_o
);
  logic [NS-1:0]        vld_q;
  logic [NS-1:0][W-1:0] rec_q;
  logic [NS-1:0]        head_oh;

  // lowest occupied slot leads; slot order is record order
  always_comb begin
    logic found;
    found      = 1'b0;
    head_rec_o = '0;
    for (int i = 0; i < NS; i++) begin
      head_oh[i] = vld_q[i] & ~found;
      found      = found | vld_q[i];
      if (head_oh[i]) head_rec_o = head_rec_o | rec_q[i];
    end
  end

  assign busy_o     = |vld_q;
  assign head_vld_o = |vld_q;

  for (genvar g = 0; g < NS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        rec_q[g] <= '0;
      end else if (clr_i) begin
        vld_q[g] <= 1'b0;
      end else if (load_i) begin
        vld_q[g] <= load_vld_i[g];
        rec_q[g] <= load_rec_i[g];
      end else if (pop_i && head_oh[g]) begin
        vld_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/exc_trace_seq.sv
module exc_trace_seq #(
  parameter int          AW      = 32,
  parameter int          AMAX    = 5,
  parameter logic [31:0] IRQ_VEC = 32'h0000_0018,
  parameter logic [31:0] FIQ_VEC = 32'h0000_001C,
  localparam int         CW      = $clog2(AMAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trace_en_i,
  output logic            in_ready_o,
  input  logic            retire_valid_i,
  input  logic [AW-1:0]   retire_addr_i,
  input  logic            retire_wpt_i,
  input  logic            retire_taken_i,
  input  logic            branch_valid_i,
  input  logic [AW-1:0]   branch_dest_i,
  input  logic            exc_valid_i,
  input  logic            exc_type_i,
  output logic            pkt_valid_o,
  input  logic            pkt_ready_i,
  output logic [2:0]      pkt_kind_o,
  output logic [AW-1:0]   pkt_addr_o,
  output logic            pkt_exc_o,
  output logic [AMAX-1:0] pkt_atoms_o,
  output logic [CW-1:0]   pkt_cnt_o
);
  import exc_trace_pkg::*;

  localparam int NS    = 3;
  localparam int REC_W = 3 + AW + 1 + AMAX + CW;

  logic            busy, head_vld;
  logic [REC_W-1:0] head_rec;
  logic            ev_ret, ev_exc, ev_br, any_ev;
  logic [AW-1:0]   exc_vec;
  logic [AW-1:0]   last_addr, last_vec;
  logic            last_wpt, ret_since, vec_valid, sync_pend;
  logic            eff_since, eff_wpt;
  logic [AW-1:0]   eff_addr;
  logic            promote, do_sync, addr_pkt, flush_now, push_atom;
  logic [CW-1:0]   nxt_cnt;
  logic [AMAX-1:0] nxt_bits;
  logic            load;
  logic [NS-1:0]            load_vld;
  logic [NS-1:0][REC_W-1:0] load_rec;

  assign in_ready_o = ~busy;
  assign ev_ret     = retire_valid_i & in_ready_o;
  assign ev_exc     = exc_valid_i & in_ready_o;
  assign ev_br      = branch_valid_i & in_ready_o & ~exc_valid_i;
  assign any_ev     = ev_ret | ev_exc | ev_br;
  assign exc_vec    = exc_type_i ? FIQ_VEC[AW-1:0] : IRQ_VEC[AW-1:0];

  trace_exec_track #(.AW(AW)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trace_en_i  (trace_en_i),
    .ret_i       (ev_ret),
    .ret_addr_i  (retire_addr_i),
    .ret_wpt_i   (retire_wpt_i),
    .exc_i       (ev_exc),
    .exc_vec_i   (exc_vec),
    .any_ev_i    (any_ev),
    .last_addr_o (last_addr),
    .last_wpt_o  (last_wpt),
    .ret_since_o (ret_since),
    .last_vec_o  (last_vec),
    .vec_valid_o (vec_valid),
    .sync_pend_o (sync_pend)
  );

  // a same-cycle retire is seen before the exception
  assign eff_since = ret_since | ev_ret;
  assign eff_wpt   = ev_ret ? retire_wpt_i : last_wpt;
  assign eff_addr  = ev_ret ? retire_addr_i : last_addr;

  assign push_atom = trace_en_i & ev_ret & retire_wpt_i;
  assign addr_pkt  = ev_exc | ev_br;
  assign promote   = ev_exc & eff_since & ~eff_wpt;
  assign do_sync   = ev_exc & ~eff_since & vec_valid & sync_pend;
  assign flush_now = trace_en_i & ((nxt_cnt == CW'(AMAX)) | (addr_pkt & (nxt_cnt != '0)));

  trace_atom_acc #(.AMAX(AMAX), .CW(CW)) u_atoms (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (~trace_en_i),
    .push_i     (push_atom),
    .bit_i      (retire_taken_i),
    .flush_i    (flush_now),
    .nxt_cnt_o  (nxt_cnt),
    .nxt_bits_o (nxt_bits)
  );

  always_comb begin
    load_vld    = '0;
    load_rec    = '0;
    load_vld[0] = flush_now;
    load_rec[0] = {PK_ATOM, {AW{1'b0}}, 1'b0, nxt_bits, nxt_cnt};
    if (promote) begin
      load_vld[1] = 1'b1;
      load_rec[1] = {PK_WPT, eff_addr, 1'b0, {AMAX{1'b0}}, {CW{1'b0}}};
    end else if (do_sync) begin
      load_vld[1] = 1'b1;
      load_rec[1] = {PK_ISYNC, last_vec, 1'b0, {AMAX{1'b0}}, {CW{1'b0}}};
    end
    if (ev_exc) begin
      load_vld[2] = 1'b1;
      load_rec[2] = {PK_EXC, exc_vec, exc_type_i, {AMAX{1'b0}}, {CW{1'b0}}};
    end else if (ev_br) begin
      load_vld[2] = 1'b1;
      load_rec[2] = {PK_BR, branch_dest_i, 1'b0, {AMAX{1'b0}}, {CW{1'b0}}};
    end
  end

  assign load = trace_en_i & any_ev;

  trace_pkt_slots #(.NS(NS), .W(REC_W)) u_slots (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (~trace_en_i),
    .load_i     (load),
    .load_vld_i (load_vld),
    .load_rec_i (load_rec),
    .pop_i      (pkt_valid_o & pkt_ready_i),
    .busy_o     (busy),
    .head_vld_o (head_vld),
    .head_rec_o (head_rec)
  );

  assign pkt_valid_o = head_vld & trace_en_i;
  assign {pkt_kind_o, pkt_addr_o, pkt_exc_o, pkt_atoms_o, pkt_cnt_o} = head_rec;
endmodule

// File: rtl/exc_trace_seq_chk.sv
module exc_trace_seq_chk #(
  parameter int          AW      = 32,
  parameter int          AMAX    = 5,
  parameter logic [31:0] IRQ_VEC = 32'h0000_0018,
  parameter logic [31:0] FIQ_VEC = 32'h0000_001C,
  localparam int         CW      = $clog2(AMAX + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            trace_en_i,
  input logic            in_ready_o,
  input logic            retire_valid_i,
  input logic [AW-1:0]   retire_addr_i,
  input logic            retire_wpt_i,
  input logic            retire_taken_i,
  input logic            branch_valid_i,
  input logic [AW-1:0]   branch_dest_i,
  input logic            exc_valid_i,
  input logic            exc_type_i,
  input logic            pkt_valid_o,
  input logic            pkt_ready_i,
  input logic [2:0]      pkt_kind_o,
  input logic [AW-1:0]   pkt_addr_o,
  input logic            pkt_exc_o,
  input logic [AMAX-1:0] pkt_atoms_o,
  input logic [CW-1:0]   pkt_cnt_o
);
  assert_quiet_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trace_en_i |-> !pkt_valid_o);

  assert_stall_in_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> !in_ready_o);

  assert_hold_rec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> (!trace_en_i ||
      (pkt_valid_o && $stable(pkt_kind_o) && $stable(pkt_addr_o) &&
       $stable(pkt_exc_o) && $stable(pkt_atoms_o) && $stable(pkt_cnt_o))));

  assert_atom_cnt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_kind_o == 3'd0) |-> (pkt_cnt_o != '0 && pkt_cnt_o <= CW'(AMAX)));

  assert_wpt_then_exc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_ready_i && pkt_kind_o == 3'd1) |=>
      (!trace_en_i || (pkt_valid_o && pkt_kind_o == 3'd2)));

  assert_sync_then_exc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_ready_i && pkt_kind_o == 3'd4) |=>
      (!trace_en_i || (pkt_valid_o && pkt_kind_o == 3'd2)));

  assert_vector_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && pkt_kind_o == 3'd2) |->
      (pkt_addr_o == (pkt_exc_o ? FIQ_VEC[AW-1:0] : IRQ_VEC[AW-1:0])));
endmodule

bind exc_trace_seq exc_trace_seq_chk #(
  .AW(AW), .AMAX(AMAX), .IRQ_VEC(IRQ_VEC), .FIQ_VEC(FIQ_VEC)
) u_chk (.*);

// File: tb/sim_exc_trace_seq.sv
module sim_exc_trace_seq;
  localparam int AW = 32;
  localparam int AMAX = 5;
  localparam int CW = 3;

  logic clk = 1'b0, rst_n = 1'b0, trace_en = 1'b1;
  logic in_ready, ret_v = 0, ret_wpt = 0, ret_tk = 0, br_v = 0, exc_v = 0, exc_t = 0;
  logic [AW-1:0] ret_addr = '0, br_dest = '0;
  logic pkt_valid, pkt_ready = 1'b1, pkt_exc;
  logic [2:0] pkt_kind;
  logic [AW-1:0] pkt_addr;
  logic [AMAX-1:0] pkt_atoms;
  logic [CW-1:0] pkt_cnt;

  always #10 clk = ~clk;

  exc_trace_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .trace_en_i(trace_en), .in_ready_o(in_ready),
    .retire_valid_i(ret_v), .retire_addr_i(ret_addr), .retire_wpt_i(ret_wpt),
    .retire_taken_i(ret_tk), .branch_valid_i(br_v), .branch_dest_i(br_dest),
    .exc_valid_i(exc_v), .exc_type_i(exc_t), .pkt_valid_o(pkt_valid),
    .pkt_ready_i(pkt_ready), .pkt_kind_o(pkt_kind), .pkt_addr_o(pkt_addr),
    .pkt_exc_o(pkt_exc), .pkt_atoms_o(pkt_atoms), .pkt_cnt_o(pkt_cnt));

  typedef struct {int kind; logic [AW-1:0] addr; bit exc; logic [AMAX-1:0] atoms; int cnt;} rec_t;
  rec_t q[$];
  bit abits[$];
  logic [AW-1:0] m_addr = '0, m_vec = '0;
  bit m_wpt = 0, m_ret = 0, m_vv = 0, m_sync = 0;
  int checks = 0, errors = 0, cycles = 0;
  bit rnd_rdy = 0, done = 0;
  string cur_req = "R1";

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic push_rec(int k, logic [AW-1:0] a, bit e, logic [AMAX-1:0] b, int c);
    rec_t r;
    r.kind = k; r.addr = a; r.exc = e; r.atoms = b; r.cnt = c;
    q.push_back(r);
  endtask

  task automatic flush_atoms();
    logic [AMAX-1:0] b;
    b = '0;
    for (int i = 0; i < abits.size(); i++) b[i] = abits[i];
    push_rec(0, '0, 0, b, abits.size());
    abits.delete();
  endtask

  task automatic compare();
    bit ev;
    chk(in_ready == (q.size() == 0), "in_ready", in_ready, q.size() == 0);
    ev = trace_en && q.size() > 0;
    chk(pkt_valid == ev, "valid", pkt_valid, ev);
    if (ev && pkt_valid) begin
      chk(pkt_kind == q[0].kind[2:0], "kind", pkt_kind, q[0].kind);
      chk(pkt_addr == q[0].addr, "addr", pkt_addr, q[0].addr);
      chk(pkt_exc == q[0].exc, "exc", pkt_exc, q[0].exc);
      chk(pkt_atoms == q[0].atoms, "atoms", pkt_atoms, q[0].atoms);
      chk(pkt_cnt == CW'(q[0].cnt), "cnt", pkt_cnt, q[0].cnt);
    end
  endtask

  task automatic tick();
    bit acc, er, ee, eb, since, wpt;
    logic [AW-1:0] ad;
    if (rnd_rdy) pkt_ready = 1'($urandom_range(0, 1));
    acc = (q.size() == 0);
    er = acc && ret_v; ee = acc && exc_v; eb = acc && br_v && !exc_v;
    if (trace_en && q.size() > 0 && pkt_ready) void'(q.pop_front());
    if (!trace_en) begin
      q.delete(); abits.delete();
    end else if (er || ee || eb) begin
      since = m_ret || er; wpt = er ? ret_wpt : m_wpt; ad = er ? ret_addr : m_addr;
      if (er && ret_wpt) abits.push_back(ret_tk);
      if (abits.size() == AMAX || ((ee || eb) && abits.size() > 0)) flush_atoms();
      if (ee && since && !wpt) push_rec(1, ad, 0, '0, 0);
      else if (ee && !since && m_vv && m_sync) push_rec(4, m_vec, 0, '0, 0);
      if (ee) push_rec(2, exc_t ? 32'h1C : 32'h18, exc_t, '0, 0);
      else if (eb) push_rec(3, br_dest, 0, '0, 0);
    end
    if (er) begin m_addr = ret_addr; m_wpt = ret_wpt; m_ret = 1; end
    if (ee) begin m_ret = 0; m_vec = exc_t ? 32'h1C : 32'h18; m_vv = 1; end
    if (!trace_en) m_sync = 1; else if (er || ee || eb) m_sync = 0;
    @(posedge clk); @(negedge clk);
    cycles++;
    compare();
  endtask

  task automatic ev(bit rv, logic [AW-1:0] ra, bit rw, bit rt, bit xv, bit xt, bit bv, logic [AW-1:0] bd);
    bit a;
    ret_v = rv; ret_addr = ra; ret_wpt = rw; ret_tk = rt;
    exc_v = xv; exc_t = xt; br_v = bv; br_dest = bd;
    do begin a = (q.size() == 0); tick(); end while (!a);
    ret_v = 0; exc_v = 0; br_v = 0;
  endtask

  task automatic ret(logic [AW-1:0] a, bit w, bit t); ev(1, a, w, t, 0, 0, 0, '0); endtask
  task automatic exc(bit t); ev(0, '0, 0, 0, 1, t, 0, '0); endtask
  task automatic drain(); while (q.size() > 0) tick(); tick(); endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    chk(in_ready === 1'b1, "reset in_ready", in_ready, 1);
    chk(pkt_valid === 1'b0, "reset valid", pkt_valid, 0);
    tick();

    cur_req = "R2";
    ret(32'h100, 1, 1); ret(32'h104, 1, 0); ret(32'h108, 1, 1); ret(32'h10C, 1, 1);
    chk(pkt_valid == 0, "no atoms before five", pkt_valid, 0);
    ret(32'h110, 1, 0);
    drain();

    cur_req = "R3";
    ret(32'h200, 1, 1); ret(32'h204, 1, 0); ret(32'h1000, 0, 0);
    exc(0);
    drain();

    cur_req = "R5";
    exc(1);
    drain();

    cur_req = "R7";
    ev(1, 32'h1C, 1, 1, 0, 0, 1, 32'h2000);
    drain();
    ev(1, 32'h2100, 1, 1, 0, 0, 1, 32'h18);
    drain();

    cur_req = "R4";
    ret(32'h18, 1, 0);
    exc(1);
    drain();

    cur_req = "R6";
    ret(32'h1000, 0, 0);
    exc(0); exc(1);
    drain();

    cur_req = "R8";
    ret(32'h1000, 0, 0);
    trace_en = 0; tick();
    exc(0);
    trace_en = 1; tick();
    exc(1);
    drain();

    cur_req = "R9";
    ret(32'h300, 1, 1); ret(32'h304, 1, 1);
    trace_en = 0; tick(); tick();
    trace_en = 1; tick();
    cur_req = "R11";
    ev(1, 32'h500, 0, 0, 1, 0, 0, '0);
    drain();
    ev(1, 32'h600, 1, 1, 1, 1, 0, '0);
    drain();

    cur_req = "R9";
    pkt_ready = 0;
    ret(32'h700, 0, 0);
    exc(0);
    tick();
    trace_en = 0; tick();
    trace_en = 1; tick();
    chk(pkt_valid == 0, "staged records dropped", pkt_valid, 0);
    pkt_ready = 1;

    cur_req = "R10";
    pkt_ready = 0;
    ret(32'h800, 1, 1); ret(32'h804, 0, 0);
    exc(1);
    repeat (6) tick();
    pkt_ready = 1;
    drain();

    cur_req = "R11";
    rnd_rdy = 1;
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = $urandom_range(0, 19);
      if (sel == 0) begin
        trace_en = 0; tick(); trace_en = 1;
      end else if (sel < 4) begin
        ev($urandom_range(0, 1), 32'($urandom_range(0, 4095)) << 1, $urandom_range(0, 1),
           $urandom_range(0, 1), 1, $urandom_range(0, 1), 0, '0);
      end else if (sel < 7) begin
        ev(1, 32'($urandom_range(0, 4095)) << 1, 1, 1, 0, 0, 1, 32'($urandom_range(0, 4095)) << 2);
      end else begin
        ret(32'($urandom_range(0, 4095)) << 1, $urandom_range(0, 1), $urandom_range(0, 1));
      end
    end
    rnd_rdy = 0; pkt_ready = 1;
    drain();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule